// File: doc/BRIEF.md
# SM4 Iterative Block Cipher Engine

The engine encrypts or decrypts a single 128-bit block under a 128-bit key. One round of the data path runs per clock. A key scheduler runs beside the data path and also produces one round key per clock. The block and the key are each handled as four 32-bit words, with word 0 in the most significant position. Every round computes the new word from the oldest word XORed with the nonlinear transform of the other three words and the round key. The transform applies the byte S-box to each byte and then a rotate-and-XOR linear mix. The S-box is built from logic: a GF(2^8) inversion enclosed by two affine steps. It holds no stored table.

Each encryption writes its 32 round keys into a local register file and records the key it used. A decryption under the recorded key reads those round keys in reverse order and takes the same 32 cycles as an encryption. A decryption under any other key, or the first decryption after reset, first runs a 32-cycle expansion pass and then the 32 rounds. Latency therefore depends only on the mode and on whether the key is new, and never on the data.

Top module: `sm4_cipher`

## Requirements
- R1: Encryption follows SM4. Key and plaintext 0123456789ABCDEFFEDCBA9876543210 give ciphertext 681EDF34D206965E86B3E94F536E4246. The result is the last four round words in reverse order, with the last-produced word at bits [127:96].
- R2: With decrypt_i=1, the same rounds run with the round keys in reverse order, so decrypting a ciphertext under its key returns the plaintext.
- R3: An encryption raises valid_o exactly 32 clock edges after the edge that accepts start_i, whatever the key and data.
- R4: A decryption whose key equals the key of the most recently accepted operation raises valid_o 32 edges after acceptance.
- R5: A decryption under a different key, or the first decryption after reset, raises valid_o 64 edges after acceptance: 32 cycles of expansion, then 32 rounds.
- R6: busy_o goes high on the edge that accepts start_i and stays high until the edge that raises valid_o, where it drops.
- R7: valid_o is a one-cycle pulse. block_o changes only on the edge that raises valid_o and holds its value until the next completion.
- R8: start_i is ignored while busy_o is high. The result in progress does not change, and the recorded key does not change.
- R9: After reset, busy_o=0, valid_o=0, block_o=0, and no key is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only while idle |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt, sampled with start_i |
| key_i | input | 128 | Cipher key, sampled with start_i |
| block_i | input | 128 | Input block, sampled with start_i |
| busy_o | output | 1 | Operation in progress |
| block_o | output | 128 | Result block, held between completions |
| valid_o | output | 1 | One-cycle completion pulse |

## Verification
The bench covers the following corner cases:
- A first decryption after reset under the all-zero key. This key equals the reset value of the key register. A design that trusted the register without a recorded-key flag would finish in 32 cycles and use garbage round keys.
- Alternating encryptions and decryptions with reused and fresh keys. A wrong round-key order, or a missed key change, shows up as wrong data or as the wrong 32/64-cycle latency.
- A second start pulsed mid-operation with another key. A design that let this start through would corrupt the result, or would make the next same-key decryption take 64 cycles.
- The known-answer vector. It pins the byte order, the output word reversal and the S-box.

// File: rtl/sm4_pkg.sv
package sm4_pkg;

  localparam logic [127:0] SM4_FK = 128'hA3B1BAC6_56AA3350_677D9197_B27022DC;

  typedef enum logic [1:0] {ST_IDLE, ST_EXPAND, ST_RUN} sm4_state_e;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] t;
    p = '0;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= t;
      t = t[7] ? ((t << 1) ^ 8'hF5) : (t << 1);
    end
    return p;
  endfunction

  // a^254 = a^-1 (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] a3, a7, a15, a31, a63, a127;
    a3   = gf_mul(gf_mul(a, a), a);
    a7   = gf_mul(gf_mul(a3, a3), a);
    a15  = gf_mul(gf_mul(a7, a7), a);
    a31  = gf_mul(gf_mul(a15, a15), a);
    a63  = gf_mul(gf_mul(a31, a31), a);
    a127 = gf_mul(gf_mul(a63, a63), a);
    return gf_mul(a127, a127);
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] x);
    logic [15:0] d;
    logic [7:0]  y;
    d = {8'hA7, 8'hA7};
    for (int j = 0; j < 8; j++) y[j] = ^(d[15-j -: 8] & x);
    return y;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    return affine(gf_inv(affine(x) ^ 8'hD3)) ^ 8'hD3;
  endfunction

  function automatic logic [31:0] rol32(input logic [31:0] w, input int unsigned n);
    return (w << n) | (w >> (32 - n));
  endfunction

  function automatic logic [31:0] tau(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [31:0] lin_dat(input logic [31:0] b);
    return b ^ rol32(b, 2) ^ rol32(b, 10) ^ rol32(b, 18) ^ rol32(b, 24);
  endfunction

  function automatic logic [31:0] lin_key(input logic [31:0] b);
    return b ^ rol32(b, 13) ^ rol32(b, 23);
  endfunction

  function automatic logic [31:0] ck_word(input logic [7:0] i);
    logic [31:0] c;
    for (int j = 0; j < 4; j++) c[31-8*j -: 8] = 8'((32'(i) * 4 + 32'(j)) * 7);
    return c;
  endfunction

endpackage

// File: rtl/sm4_keygen.sv
module sm4_keygen
  import sm4_pkg::*;
#(
  parameter int unsigned ROUNDS = 32,
  localparam int unsigned IW = $clog2(ROUNDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [127:0]  key_i,
  input  logic          step_i,
  input  logic [IW-1:0] idx_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [31:0]   rk_o,
  output logic [31:0]   rk_rd_o
);

  logic [31:0] k_q  [4];
  logic [31:0] rf_q [ROUNDS];

  assign rk_o    = k_q[0] ^ lin_key(tau(k_q[1] ^ k_q[2] ^ k_q[3] ^ ck_word(8'(idx_i))));
  assign rk_rd_o = rf_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < 4; w++) k_q[w] <= '0;
    end else if (load_i) begin
      for (int w = 0; w < 4; w++) k_q[w] <= key_i[127-32*w -: 32] ^ SM4_FK[127-32*w -: 32];
    end else if (step_i) begin
      k_q[0] <= k_q[1];
      k_q[1] <= k_q[2];
      k_q[2] <= k_q[3];
      k_q[3] <= rk_o;
    end
  end

  // round-key file: datapath storage, no reset
  always_ff @(posedge clk_i) begin
    if (step_i) rf_q[idx_i] <= rk_o;
  end

endmodule

// File: rtl/sm4_round_dp.sv
module sm4_round_dp
  import sm4_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [127:0] block_i,
  input  logic         step_i,
  input  logic [31:0]  rk_i,
  output logic [127:0] nxt_o
);

  logic [31:0] x_q [4];
  logic [31:0] f;

  assign f     = x_q[0] ^ lin_dat(tau(x_q[1] ^ x_q[2] ^ x_q[3] ^ rk_i));
  assign nxt_o = {x_q[1], x_q[2], x_q[3], f};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < 4; w++) x_q[w] <= '0;
    end else if (load_i) begin
      for (int w = 0; w < 4; w++) x_q[w] <= block_i[127-32*w -: 32];
    end else if (step_i) begin
      x_q[0] <= x_q[1];
      x_q[1] <= x_q[2];
      x_q[2] <= x_q[3];
      x_q[3] <= f;
    end
  end

endmodule

// File: rtl/sm4_cipher.sv
module sm4_cipher
  import sm4_pkg::*;
#(
  parameter int unsigned ROUNDS = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         decrypt_i,
  input  logic [127:0] key_i,
  input  logic [127:0] block_i,
  output logic         busy_o,
  output logic [127:0] block_o,
  output logic         valid_o
);

  localparam int unsigned IW = $clog2(ROUNDS);
  localparam logic [IW-1:0] LAST = IW'(ROUNDS - 1);

  sm4_state_e   state_q;
  logic [IW-1:0] cnt_q;
  logic         dec_q;
  logic [127:0] key_q;
  logic         key_ok_q;

  logic         accept, key_new, kg_load, kg_step, dp_step, last;
  logic [IW-1:0] rd_idx;
  logic [31:0]  rk_new, rk_rd, rk_dp;
  logic [127:0] nxt, out_rev;

  assign accept  = start_i && (state_q == ST_IDLE);
  assign key_new = !key_ok_q || (key_i != key_q);
  assign kg_load = accept && (!decrypt_i || key_new);
  assign kg_step = (state_q == ST_EXPAND) || ((state_q == ST_RUN) && !dec_q);
  assign dp_step = (state_q == ST_RUN);
  assign last    = (cnt_q == LAST);
  assign rd_idx  = LAST - cnt_q;
  assign rk_dp   = dec_q ? rk_rd : rk_new;
  assign busy_o  = (state_q != ST_IDLE);

  sm4_keygen #(.ROUNDS(ROUNDS)) u_keygen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (kg_load),
    .key_i    (key_i),
    .step_i   (kg_step),
    .idx_i    (cnt_q),
    .rd_idx_i (rd_idx),
    .rk_o     (rk_new),
    .rk_rd_o  (rk_rd)
  );

  sm4_round_dp u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .block_i (block_i),
    .step_i  (dp_step),
    .rk_i    (rk_dp),
    .nxt_o   (nxt)
  );

  // output = last four words, newest first
  for (genvar g = 0; g < 4; g++) begin : g_rev
    assign out_rev[32*g +: 32] = nxt[127-32*g -: 32];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      dec_q    <= 1'b0;
      key_q    <= '0;
      key_ok_q <= 1'b0;
      block_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          dec_q    <= decrypt_i;
          key_q    <= key_i;
          key_ok_q <= 1'b1;
          cnt_q    <= '0;
          state_q  <= (decrypt_i && key_new) ? ST_EXPAND : ST_RUN;
        end
        ST_EXPAND: begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) state_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) begin
            state_q <= ST_IDLE;
            valid_o <= 1'b1;
            block_o <= out_rev;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sm4_cipher_chk.sv
module sm4_cipher_chk #(
  parameter int unsigned ROUNDS = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         valid_o,
  input logic [127:0] block_o
);

  localparam int unsigned LW = $clog2(2 * ROUNDS) + 2;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_q <= '0;
    else if (start_i && !busy_o)  lat_q <= '0;
    else if (busy_o)              lat_q <= lat_q + 1'b1;
  end

  assert_valid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_block_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(block_o));

  assert_busy_on_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);

  assert_idle_at_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);

  // 32 cycles normally, 64 when expansion precedes decryption (R5)
  assert_fixed_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (lat_q == LW'(ROUNDS) || lat_q == LW'(2 * ROUNDS)));

endmodule

bind sm4_cipher sm4_cipher_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .block_o (block_o)
);

// File: tb/tb_sm4_cipher.sv
module tb_sm4_cipher;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         decrypt_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [127:0] block_i = '0;
  logic         busy_o;
  logic [127:0] block_o;
  logic         valid_o;

  int checks = 0;
  int failures = 0;

  logic [7:0]   sb [256];
  logic [127:0] last_key = '0;
  logic         have_key = 1'b0;

  always #2 clk_i = ~clk_i;

  sm4_cipher dut (.*);

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = '0;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= t;
      t = t[7] ? ((t << 1) ^ 8'hF5) : (t << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] m_aff(input logic [7:0] x);
    logic [7:0] y;
    for (int j = 0; j < 8; j++)
      y[j] = x[j] ^ x[(j+1)%8] ^ x[(j+2)%8] ^ x[(j+5)%8] ^ x[(j+7)%8];
    return y;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] a = m_aff(8'(x)) ^ 8'hD3;
      logic [7:0] inv = '0;
      for (int y = 1; y < 256; y++) if (m_mul(a, 8'(y)) == 8'h01) inv = 8'(y);
      sb[x] = m_aff(inv) ^ 8'hD3;
    end
  endtask

  function automatic logic [31:0] m_rol(input logic [31:0] w, input int n);
    return (w << n) | (w >> (32 - n));
  endfunction

  function automatic logic [31:0] m_sub(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [127:0] ref_sm4(input logic [127:0] k, input logic [127:0] b, input logic dec);
    logic [31:0] kw [36];
    logic [31:0] rk [32];
    logic [31:0] x  [36];
    logic [127:0] fk = 128'hA3B1BAC6_56AA3350_677D9197_B27022DC;
    for (int i = 0; i < 4; i++) begin
      kw[i] = k[127-32*i -: 32] ^ fk[127-32*i -: 32];
      x[i]  = b[127-32*i -: 32];
    end
    for (int i = 0; i < 32; i++) begin
      logic [31:0] ck, s;
      for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'(((4*i + j) * 7) % 256);
      s = m_sub(kw[i+1] ^ kw[i+2] ^ kw[i+3] ^ ck);
      kw[i+4] = kw[i] ^ s ^ m_rol(s, 13) ^ m_rol(s, 23);
      rk[i] = kw[i+4];
    end
    for (int i = 0; i < 32; i++) begin
      logic [31:0] s;
      s = m_sub(x[i+1] ^ x[i+2] ^ x[i+3] ^ (dec ? rk[31-i] : rk[i]));
      x[i+4] = x[i] ^ s ^ m_rol(s, 2) ^ m_rol(s, 10) ^ m_rol(s, 18) ^ m_rol(s, 24);
    end
    return {x[35], x[34], x[33], x[32]};
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [127:0] k, input logic d);
    return (d && (!have_key || k != last_key)) ? 64 : 32;
  endfunction

  task automatic run_op(input logic [127:0] k, input logic [127:0] b, input logic d,
                        output logic [127:0] res, output int lat);
    @(negedge clk_i);
    key_i = k; block_i = b; decrypt_i = d; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    chk("R6 busy after accept", 128'(busy_o), 128'd1);
    while (!valid_o && lat < 200) begin
      @(negedge clk_i);
      lat++;
    end
    res = block_o;
    chk("R6 busy low at done", 128'(busy_o), 128'd0);
    @(negedge clk_i);
    chk("R7 valid single pulse", 128'(valid_o), 128'd0);
    chk("R7 block held", block_o, res);
  endtask

  task automatic op_check(input string tag, input logic [127:0] k, input logic [127:0] b, input logic d);
    logic [127:0] res;
    int lat, el;
    el = exp_lat(k, d);
    run_op(k, b, d, res, lat);
    chk({tag, " data"}, res, ref_sm4(k, b, d));
    chk(el == 64 ? "R5 latency" : (d ? "R4 latency" : "R3 latency"), 128'(lat), 128'(el));
    last_key = k;
    have_key = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [127:0] std_v, ct, res, ka, kb, pa, pb;
    int lat;
    void'($urandom(32'h5EED_1234));
    build_sbox();
    std_v = 128'h0123456789ABCDEFFEDCBA9876543210;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 busy after reset", 128'(busy_o), 128'd0);
    chk("R9 valid after reset", 128'(valid_o), 128'd0);
    chk("R9 block after reset", block_o, 128'd0);

    // zero key equals key register reset value; no key recorded yet (R9, R5)
    op_check("R9 R5 first decrypt zero key", 128'd0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 1'b1);

    // known answer (R1)
    op_check("R1 vector", std_v, std_v, 1'b0);
    run_op(std_v, std_v, 1'b0, ct, lat);
    chk("R1 known ciphertext", ct, 128'h681EDF34D206965E86B3E94F536E4246);
    chk("R3 latency vector", 128'(lat), 128'd32);

    // decrypt back with stored keys (R2, R4)
    op_check("R2 decrypt same key", std_v, ct, 1'b0 ^ 1'b1);
    run_op(std_v, ct, 1'b1, res, lat);
    chk("R2 round trip", res, std_v);
    chk("R4 latency stored key", 128'(lat), 128'd32);

    // start while busy is ignored (R8)
    ka = {$urandom, $urandom, $urandom, $urandom};
    kb = {$urandom, $urandom, $urandom, $urandom};
    pa = {$urandom, $urandom, $urandom, $urandom};
    pb = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk_i);
    key_i = ka; block_i = pa; decrypt_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    repeat (5) begin @(negedge clk_i); lat++; end
    key_i = kb; block_i = pb; decrypt_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    lat++;
    start_i = 1'b0;
    while (!valid_o && lat < 200) begin @(negedge clk_i); lat++; end
    chk("R8 result unaffected", block_o, ref_sm4(ka, pa, 1'b0));
    chk("R8 latency unaffected", 128'(lat), 128'd32);
    last_key = ka;
    have_key = 1'b1;
    op_check("R8 recorded key kept", ka, ref_sm4(ka, pa, 1'b0), 1'b1);

    // new-key decrypt then same-key decrypt (R5, R4)
    op_check("R5 decrypt new key", kb, pb, 1'b1);
    op_check("R4 decrypt repeat key", kb, pa, 1'b1);

    // random mix (R1 R2 R3 R4 R5)
    for (int n = 0; n < 30; n++) begin
      logic [127:0] k, b;
      logic d;
      k = ($urandom % 2) ? last_key : {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      d = 1'($urandom % 2);
      op_check(d ? "R2 random decrypt" : "R1 random encrypt", k, b, d);
    end

    // random round trips (R2)
    for (int n = 0; n < 6; n++) begin
      logic [127:0] k, p, c, q;
      k = {$urandom, $urandom, $urandom, $urandom};
      p = {$urandom, $urandom, $urandom, $urandom};
      run_op(k, p, 1'b0, c, lat);
      run_op(k, c, 1'b1, q, lat);
      chk("R2 random round trip", q, p);
      chk("R4 latency after encrypt", 128'(lat), 128'd32);
      last_key = k;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule